// File: doc/BRIEF.md
# Banked Level-Interrupt Controller with Fast-Interrupt Routing

This block gathers 64 level-sensitive peripheral interrupt lines, split into two banks of 32, and 8 level-sensitive core-local lines. Each source is gated by its own bit in an enable mask. Software changes the mask only through write-one-to-set and write-one-to-clear registers. The block drives two outputs. The normal interrupt output is the OR of every active, enabled source. The fast-interrupt output follows the raw level of one source that software selects.

Software reads, through a 32-bit word register interface, the masked pending state of each peripheral bank and a summary word. The summary word packs the local pending bits, a per-bank "anything pending" flag and copies of eleven fixed peripheral sources. A handler can often find the cause in the summary word with a single read. Reads are combinational in the cycle of the read strobe. Both interrupt outputs are registered, so each one lags its cause by one clock.

Top module: `irq_bank_ctrl`

## Requirements
- R1: Asynchronous reset clears every enable bit, the fast-interrupt enable and the fast-interrupt select, and drives both interrupt outputs low.
- R2: A write to 0x10 (peripherals 0–31), 0x14 (peripherals 32–63) or 0x18 (local lines, data bits 7:0 only) ORs the one bits of the data into the enable mask. Zero bits leave the mask unchanged.
- R3: A write to 0x1C, 0x20 or 0x24 (same bank order as R2) clears the mask bits where the data has ones. For 0x24 only data bits 7:0 take effect.
- R4: A read of 0x10, 0x14 or 0x18 returns the current mask, zero-extended. A read of 0x1C, 0x20 or 0x24 returns the bitwise inverse of the full 32-bit zero-extended mask, so the upper 24 bits of a 0x24 read are ones.
- R5: A read of 0x04 returns raw level AND enable for peripherals 0–31. A read of 0x08 does the same for peripherals 32–63.
- R6: In the summary word at 0x00, bits 7:0 are the local lines that are active and enabled. Bit 8 is set when any of peripherals 0–31 is pending, and bit 9 when any of peripherals 32–63 is pending.
- R7: Summary bits 10 to 20 hold the pending state of peripherals 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, in that order. Summary bits 31:21 read zero.
- R8: Writing 0x0C sets the fast select from data bits 6:0 and the fast enable from bit 7. A read of 0x0C returns {enable, select} in bits 7:0, with zeros above.
- R9: While the fast enable is set and the select is 0–63, fast_irq_o follows the raw level of that peripheral, without the enable mask applied, one clock later. While the fast enable is clear, fast_irq_o is low.
- R10: Select values 64–71 route local line (select − 64) to fast_irq_o. Select values 72–127 drive it low.
- R11: irq_o goes high on the clock edge after any source is both active and enabled, and it is low on the edge after none is.
- R12: A read of any unmapped offset returns 0. A write to an unmapped offset or to a read-only offset (0x00, 0x04, 0x08) changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| periph_lvl_i | input | 64 | Peripheral interrupt levels |
| local_lvl_i | input | 8 | Core-local interrupt levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of reg_rd_i, otherwise zero |
| irq_o | output | 1 | Registered normal interrupt |
| fast_irq_o | output | 1 | Registered fast interrupt |

## Verification
A level can change on the same clock edge that an enable-clear write lands. The registered irq_o must then reflect the old mask for one cycle and the new mask on the next cycle. The bench raises peripheral 10 while it writes 0x1C to clear that same enable bit. It then checks irq_o before the edge, after the first edge (high, from the old mask) and after the second edge (low). The vector table also drives fast-select writes together with level changes, and judges fast_irq_o on the edge after the write.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int DATA_W   = 32;
  localparam int N_BANK   = 2;
  localparam int N_PERIPH = DATA_W * N_BANK;
  localparam int N_LOCAL  = 8;
  localparam int SEL_W    = 7;
  localparam int ADDR_W   = 8;
  localparam int N_DUP    = 11;
  localparam int DUP_LSB  = 10;

  localparam logic [ADDR_W-1:0] OFF_SUMMARY = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_PEND_LO = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_PEND_HI = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_FAST    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_SET_LO  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_SET_HI  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_SET_LOC = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_CLR_LO  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_CLR_HI  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CLR_LOC = 8'h24;

  // peripheral source mirrored into summary bit DUP_LSB+k
  function automatic int dup_src(input int k);
    case (k)
      0: return 7;    1: return 9;    2: return 10;   3: return 18;
      4: return 19;   5: return 53;   6: return 54;   7: return 55;
      8: return 56;   9: return 57;   default: return 62;
    endcase
  endfunction
endpackage

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (set_i) en_q <= en_q | wdata_i;
    else if (clr_i) en_q <= en_q & ~wdata_i;
  end

  assign en_o = en_q;

  // R2
  set_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> ((en_o & $past(wdata_i)) == $past(wdata_i)));
  // R3
  clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((en_o & $past(wdata_i)) == '0));
  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(en_o));
endmodule

// File: rtl/irq_fast_route.sv
module irq_fast_route
  import irq_bank_pkg::*;
(
  input  logic [N_PERIPH-1:0] periph_lvl_i,
  input  logic [N_LOCAL-1:0]  local_lvl_i,
  input  logic                fast_en_i,
  input  logic [SEL_W-1:0]    fast_sel_i,
  output logic                fast_raw_o
);
  localparam int PW = $clog2(N_PERIPH);
  localparam int LW = $clog2(N_LOCAL);
  localparam logic [SEL_W-1:0] SEL_LOC_LO = SEL_W'(N_PERIPH);
  localparam logic [SEL_W-1:0] SEL_LOC_HI = SEL_W'(N_PERIPH + N_LOCAL);

  logic [SEL_W-1:0] loc_idx;
  assign loc_idx = fast_sel_i - SEL_LOC_LO;

  always_comb begin
    fast_raw_o = 1'b0;
    if (fast_en_i) begin
      if (fast_sel_i < SEL_LOC_LO)      fast_raw_o = periph_lvl_i[fast_sel_i[PW-1:0]];
      else if (fast_sel_i < SEL_LOC_HI) fast_raw_o = local_lvl_i[loc_idx[LW-1:0]];
    end
  end
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
  import irq_bank_pkg::*;
(
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [N_PERIPH-1:0] pend_i,
  input  logic [N_LOCAL-1:0]  local_pend_i,
  input  logic [N_PERIPH-1:0] en_periph_i,
  input  logic [N_LOCAL-1:0]  en_local_i,
  input  logic                fast_en_i,
  input  logic [SEL_W-1:0]    fast_sel_i,
  output logic [DATA_W-1:0]   rdata_o
);
  logic [DATA_W-1:0] summary;
  logic [DATA_W-1:0] en_loc_w;

  assign en_loc_w = DATA_W'(en_local_i);

  always_comb begin
    summary = '0;
    summary[N_LOCAL-1:0] = local_pend_i;
    summary[N_LOCAL]     = |pend_i[DATA_W-1:0];
    summary[N_LOCAL+1]   = |pend_i[N_PERIPH-1:DATA_W];
    for (int k = 0; k < N_DUP; k++) summary[DUP_LSB+k] = pend_i[dup_src(k)];
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        OFF_SUMMARY: rdata_o = summary;
        OFF_PEND_LO: rdata_o = pend_i[DATA_W-1:0];
        OFF_PEND_HI: rdata_o = pend_i[N_PERIPH-1:DATA_W];
        OFF_FAST:    rdata_o = DATA_W'({fast_en_i, fast_sel_i});
        OFF_SET_LO:  rdata_o = en_periph_i[DATA_W-1:0];
        OFF_SET_HI:  rdata_o = en_periph_i[N_PERIPH-1:DATA_W];
        OFF_SET_LOC: rdata_o = en_loc_w;
        OFF_CLR_LO:  rdata_o = ~en_periph_i[DATA_W-1:0];
        OFF_CLR_HI:  rdata_o = ~en_periph_i[N_PERIPH-1:DATA_W];
        OFF_CLR_LOC: rdata_o = ~en_loc_w;
        default:     rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_PERIPH-1:0] periph_lvl_i,
  input  logic [N_LOCAL-1:0]  local_lvl_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                irq_o,
  output logic                fast_irq_o
);
  logic [N_PERIPH-1:0] en_periph;
  logic [N_LOCAL-1:0]  en_local;
  logic [N_PERIPH-1:0] pend;
  logic [N_LOCAL-1:0]  local_pend;
  logic                fast_en_q;
  logic [SEL_W-1:0]    fast_sel_q;
  logic                fast_raw;
  logic                irq_q, fast_q;

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] SET_OFF = OFF_SET_LO + ADDR_W'(4 * b);
    localparam logic [ADDR_W-1:0] CLR_OFF = OFF_CLR_LO + ADDR_W'(4 * b);
    irq_en_bank #(.W(DATA_W)) u_en (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (reg_wr_i && reg_addr_i == SET_OFF),
      .clr_i   (reg_wr_i && reg_addr_i == CLR_OFF),
      .wdata_i (reg_wdata_i),
      .en_o    (en_periph[b*DATA_W +: DATA_W])
    );
  end

  irq_en_bank #(.W(N_LOCAL)) u_en_loc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (reg_wr_i && reg_addr_i == OFF_SET_LOC),
    .clr_i   (reg_wr_i && reg_addr_i == OFF_CLR_LOC),
    .wdata_i (reg_wdata_i[N_LOCAL-1:0]),
    .en_o    (en_local)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_en_q  <= 1'b0;
      fast_sel_q <= '0;
    end else if (reg_wr_i && reg_addr_i == OFF_FAST) begin
      fast_en_q  <= reg_wdata_i[SEL_W];
      fast_sel_q <= reg_wdata_i[SEL_W-1:0];
    end
  end

  assign pend       = periph_lvl_i & en_periph;
  assign local_pend = local_lvl_i & en_local;

  irq_fast_route u_fast (
    .periph_lvl_i (periph_lvl_i),
    .local_lvl_i  (local_lvl_i),
    .fast_en_i    (fast_en_q),
    .fast_sel_i   (fast_sel_q),
    .fast_raw_o   (fast_raw)
  );

  irq_rd_mux u_rd (
    .rd_i         (reg_rd_i),
    .addr_i       (reg_addr_i),
    .pend_i       (pend),
    .local_pend_i (local_pend),
    .en_periph_i  (en_periph),
    .en_local_i   (en_local),
    .fast_en_i    (fast_en_q),
    .fast_sel_i   (fast_sel_q),
    .rdata_o      (reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      fast_q <= 1'b0;
    end else begin
      irq_q  <= (|pend) | (|local_pend);
      fast_q <= fast_raw;
    end
  end

  assign irq_o      = irq_q;
  assign fast_irq_o = fast_q;

  // R9
  fast_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fast_en_q |=> !fast_irq_o);
  // R10
  fast_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_en_q && fast_sel_q >= SEL_W'(N_PERIPH + N_LOCAL)) |=> !fast_irq_o);
  // R11
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((periph_lvl_i & en_periph) == '0 && (local_lvl_i & en_local) == '0) |=> !irq_o);
  // R11
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((local_lvl_i & en_local) != '0) |=> irq_o);
endmodule

// File: tb/tb_irq_bank_ctrl.sv
module tb_irq_bank_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] periph_lvl_i = '0;
  logic [7:0]  local_lvl_i = '0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, fast_irq_o;

  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  irq_bank_ctrl dut (.*);

  typedef struct packed {
    logic [15:0] tag;
    logic        wr;
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [63:0] pl;
    logic [7:0]  ll;
    logic [7:0]  ra;
    logic [31:0] er;
    logic        ei;
    logic        ef;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{"R2", 1'b1, 8'h10, 32'h0000_0480, 64'h0000_0000_0000_0080, 8'h00, 8'h10, 32'h0000_0480, 1'b1, 1'b0},
    '{"R4", 1'b0, 8'h00, 32'h0,         64'h0000_0000_0000_0080, 8'h00, 8'h1C, 32'hFFFF_FB7F, 1'b1, 1'b0},
    '{"R7", 1'b1, 8'h14, 32'h4000_0000, 64'h4000_0000_0000_0480, 8'h00, 8'h00, 32'h0010_1700, 1'b1, 1'b0},
    '{"R5", 1'b0, 8'h00, 32'h0,         64'h4000_0000_0000_0480, 8'h00, 8'h08, 32'h4000_0000, 1'b1, 1'b0},
    '{"R3", 1'b1, 8'h1C, 32'h0000_0080, 64'h4000_0000_0000_0480, 8'h00, 8'h04, 32'h0000_0400, 1'b1, 1'b0},
    '{"R6", 1'b1, 8'h18, 32'hFFFF_FF05, 64'h0,                   8'h0C, 8'h00, 32'h0000_0004, 1'b1, 1'b0},
    '{"R3", 1'b1, 8'h24, 32'h0000_0104, 64'h0,                   8'h0C, 8'h24, 32'hFFFF_FFFE, 1'b0, 1'b0},
    '{"R9", 1'b1, 8'h0C, 32'h0000_0083, 64'h0000_0000_0000_0008, 8'h0C, 8'h0C, 32'h0000_0083, 1'b0, 1'b1},
    '{"R8", 1'b1, 8'h0C, 32'h0000_00C2, 64'h0,                   8'h04, 8'h0C, 32'h0000_00C2, 1'b0, 1'b1},
    '{"R10",1'b1, 8'h0C, 32'h0000_00C8, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 8'h0C, 32'h0000_00C8, 1'b1, 1'b0},
    '{"R12",1'b1, 8'h28, 32'hFFFF_FFFF, 64'h0,                   8'h00, 8'h30, 32'h0000_0000, 1'b0, 1'b0},
    '{"R12",1'b1, 8'h04, 32'hFFFF_FFFF, 64'h0,                   8'h00, 8'h10, 32'h0000_0400, 1'b0, 1'b0},
    '{"R9", 1'b1, 8'h0C, 32'h0000_0003, 64'h0000_0000_0000_0008, 8'h00, 8'h0C, 32'h0000_0003, 1'b0, 1'b0},
    '{"R4", 1'b1, 8'h14, 32'h0000_0001, 64'h0000_0001_0000_0000, 8'h00, 8'h20, 32'hBFFF_FFFE, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_addr_i = a; reg_rd_i = 1'b1;
    #1 check(tag, reg_rdata_o, exp);
    reg_rd_i = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    check("R1 irq", 32'(irq_o), 0);
    check("R1 fast", 32'(fast_irq_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd_chk("R1", 8'h10, 32'h0);
    rd_chk("R1", 8'h0C, 32'h0);
    rd_chk("R1", 8'h1C, 32'hFFFF_FFFF);
    rd_chk("R1", 8'h24, 32'hFFFF_FFFF);

    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("%s v%0d", VECS[i].tag, i);
      periph_lvl_i = VECS[i].pl;
      local_lvl_i  = VECS[i].ll;
      reg_wr_i     = VECS[i].wr;
      reg_addr_i   = VECS[i].wa;
      reg_wdata_i  = VECS[i].wd;
      @(negedge clk_i);
      reg_wr_i = 1'b0;
      @(negedge clk_i);
      rd_chk(t, VECS[i].ra, VECS[i].er);
      check({t, " irq"}, 32'(irq_o), 32'(VECS[i].ei));
      check({t, " fast"}, 32'(fast_irq_o), 32'(VECS[i].ef));
    end

    // R11: level rise and enable clear in the same cycle
    periph_lvl_i = '0; local_lvl_i = '0;
    repeat (2) @(negedge clk_i);
    check("R11 quiet", 32'(irq_o), 0);
    periph_lvl_i = 64'h400;
    reg_wr_i = 1'b1; reg_addr_i = 8'h1C; reg_wdata_i = 32'h400;
    #1 check("R11 lag", 32'(irq_o), 0);
    @(negedge clk_i);
    reg_wr_i = 1'b0;
    check("R11 old mask", 32'(irq_o), 1);
    @(negedge clk_i);
    check("R11 new mask", 32'(irq_o), 0);
    rd_chk("R3", 8'h04, 32'h0);

    // R1 mid-run reset
    local_lvl_i = 8'h01;
    reg_wr_i = 1'b1; reg_addr_i = 8'h0C; reg_wdata_i = 32'hC0;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
    @(negedge clk_i);
    check("R10 local0", 32'(fast_irq_o), 1);
    rst_ni = 1'b0;
    #1 check("R1 async irq", 32'(irq_o), 0);
    check("R1 async fast", 32'(fast_irq_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd_chk("R1", 8'h14, 32'h0);
    rd_chk("R1", 8'h18, 32'h0);
    rd_chk("R1", 8'h0C, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule